// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a 32-bit virtual address space. Each cached translation is tagged with a virtual page number and an 8-bit address-space context. A lookup is matched against all entries in one cycle. A match yields a 31-bit physical address: the stored 19-bit physical page number sits above the 12-bit page offset, and the offset passes through untranslated. Every hit is also checked against the access rights stored in the entry. A write to a read-only page, or a user-mode access to a supervisor-only page, is reported as a fault, and in that case no usable address is given.

A lookup that finds no matching entry raises a walk request so that an external table walker can fetch the translation. The walker's result comes back through the refill port. A refill goes into the lowest-numbered empty slot if there is one. Otherwise it goes into the slot named by a round-robin pointer, which advances on every accepted refill. Two flush controls discard entries: one clears every entry, the other clears only the entries that belong to a given context.

Lookup results are registered and appear in the cycle after the request. A lookup sees the table as it stood before any refill or flush applied at the same clock edge.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid and all lookup outputs are low; the first lookup after reset misses.
- R2: A lookup whose page number (bits 31:12) and context both equal those of a valid entry sets `o_hit` in the next cycle. When the access is permitted, it also sets `o_pa_valid` with `o_paddr` = {stored page number, lookup address bits 11:0}.
- R3: An entry whose page number matches but whose context differs does not hit.
- R4: A lookup with no matching entry sets `o_walk` in the next cycle, with `o_hit`, `o_fault` and `o_pa_valid` low and `o_paddr` zero.
- R5: On a hit, a write (`lk_write`=1) to an entry refilled with `rf_wr_ok`=0, or a user access (`lk_user`=1) to an entry refilled with `rf_sup_only`=1, sets `o_fault` and keeps `o_pa_valid` low and `o_paddr` zero.
- R6: When several valid entries match, the lowest-numbered entry supplies the result.
- R7: A refill writes the lowest-numbered invalid entry when any entry is invalid, without evicting a valid entry.
- R8: When all entries are valid, a refill replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on every accepted refill.
- R9: `fl_all` invalidates every entry; lookups issued after it miss.
- R10: `fl_ctx_en` invalidates exactly the entries whose context equals `fl_ctx`; entries of other contexts keep hitting.
- R11: A refill presented in the same cycle as either flush is dropped.
- R12: In the cycle after `lk_valid` is low, `o_hit`, `o_walk`, `o_fault` and `o_pa_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_ctx | input | 8 | Current context of the lookup |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is a user-mode access |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Virtual page number to store |
| rf_ctx | input | 8 | Context to store |
| rf_ppn | input | 19 | Physical page number to store |
| rf_wr_ok | input | 1 | Page may be written |
| rf_sup_only | input | 1 | Page is restricted to supervisor mode |
| fl_all | input | 1 | Invalidate all entries |
| fl_ctx_en | input | 1 | Invalidate entries of context `fl_ctx` |
| fl_ctx | input | 8 | Context selected for flush |
| o_hit | output | 1 | Previous lookup matched an entry |
| o_pa_valid | output | 1 | Previous lookup hit and was permitted |
| o_paddr | output | 31 | Translated physical address |
| o_fault | output | 1 | Previous lookup hit but violated permissions |
| o_walk | output | 1 | Previous lookup missed; a table walk is needed |

## Verification
A corrupted valid bit or tag shows up at the ports in the cycle after the next lookup of that page: either as a walk request where a hit belongs, or as a hit on a stale page number. A wrong victim choice stays hidden until the evicted page is looked up, so the bench looks up the survivors and the newcomer right after each eviction. A wrong permission bit shows as a fault or missing fault one cycle after the lookup. The bench therefore sweeps every entry against all four access kinds.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Access rights stored alongside each cached translation.
   typedef struct packed {
      logic wr_ok;     // page may be written
      logic sup_only;  // page restricted to supervisor mode
   } tlb_perm_t;

   localparam int TLB_PERM_W = $bits(tlb_perm_t);

   function automatic logic tlb_perm_violation(
      input tlb_perm_t perm,
      input logic      is_write,
      input logic      is_user
   );
      return (is_write && !perm.wr_ok) || (is_user && perm.sup_only);
   endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int CTX_W   = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [VPN_W-1:0]   vpn_arr [ENTRIES],
   input  logic [CTX_W-1:0]   ctx_arr [ENTRIES],
   input  logic [VPN_W-1:0]   look_vpn,
   input  logic [CTX_W-1:0]   look_ctx,
   output logic               hit,
   output logic [IDX_W-1:0]   hit_idx
);

   logic [ENTRIES-1:0] match_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_vec[g]
                            && (vpn_arr[g] == look_vpn)
                            && (ctx_arr[g] == look_ctx);
   end

   // Lowest-numbered match has priority: scan downward so it is written last.
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = |match_vec;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               advance,
   output logic [IDX_W-1:0]   victim_idx
);

   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] free_idx;
   logic             any_free;

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

   assign any_free   = ~&valid_vec;
   assign victim_idx = any_free ? free_idx : rr_ptr;

   // Pointer moves on every accepted refill, free slot or not.
   always_ff @(posedge clk) begin
      if (!rst_n)       rr_ptr <= '0;
      else if (advance) rr_ptr <= rr_ptr + 1'b1;
   end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
   import tlb_pkg::*;
(
   input  logic      hit,
   input  tlb_perm_t perm,
   input  logic      is_write,
   input  logic      is_user,
   output logic      fault
);

   assign fault = hit && tlb_perm_violation(perm, is_write, is_user);

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 31,
   parameter int PAGE_W  = 12,
   parameter int CTX_W   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lk_valid,
   input  logic [VA_W-1:0]         lk_vaddr,
   input  logic [CTX_W-1:0]        lk_ctx,
   input  logic                    lk_write,
   input  logic                    lk_user,
   input  logic                    rf_valid,
   input  logic [VA_W-PAGE_W-1:0]  rf_vpn,
   input  logic [CTX_W-1:0]        rf_ctx,
   input  logic [PA_W-PAGE_W-1:0]  rf_ppn,
   input  logic                    rf_wr_ok,
   input  logic                    rf_sup_only,
   input  logic                    fl_all,
   input  logic                    fl_ctx_en,
   input  logic [CTX_W-1:0]        fl_ctx,
   output logic                    o_hit,
   output logic                    o_pa_valid,
   output logic [PA_W-1:0]         o_paddr,
   output logic                    o_fault,
   output logic                    o_walk
);

   localparam int VPN_W = VA_W - PAGE_W;
   localparam int PPN_W = PA_W - PAGE_W;
   localparam int IDX_W = $clog2(ENTRIES);

   // ---------------- elaboration checks ----------------
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ctx_tlb: ENTRIES must be a power of two, at least 2");
   end
   if (PAGE_W < 1 || PAGE_W >= VA_W) begin : g_bad_page
      $error("ctx_tlb: PAGE_W must lie between 1 and VA_W-1");
   end
   if (PA_W <= PAGE_W) begin : g_bad_pa
      $error("ctx_tlb: PA_W must exceed PAGE_W");
   end
   if (CTX_W < 1) begin : g_bad_ctx
      $error("ctx_tlb: CTX_W must be positive");
   end

   // ---------------- entry storage ----------------
   logic [ENTRIES-1:0] ent_v;
   logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
   logic [CTX_W-1:0]   ent_ctx  [ENTRIES];
   logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
   tlb_perm_t          ent_perm [ENTRIES];

   logic [ENTRIES-1:0] ctx_flush_vec;
   logic               flush_any;
   logic               refill_go;
   logic [IDX_W-1:0]   victim_idx;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cflush
      assign ctx_flush_vec[g] = (ent_ctx[g] == fl_ctx);
   end

   assign flush_any = fl_all || fl_ctx_en;
   assign refill_go = rf_valid && !flush_any;

   tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (ent_v),
      .advance    (refill_go),
      .victim_idx (victim_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_v <= '0;
      end else if (fl_all) begin
         ent_v <= '0;
      end else if (fl_ctx_en) begin
         ent_v <= ent_v & ~ctx_flush_vec;
      end else if (rf_valid) begin
         ent_v[victim_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (refill_go) begin
         ent_vpn[victim_idx]  <= rf_vpn;
         ent_ctx[victim_idx]  <= rf_ctx;
         ent_ppn[victim_idx]  <= rf_ppn;
         ent_perm[victim_idx] <= '{wr_ok: rf_wr_ok, sup_only: rf_sup_only};
      end
   end

   // ---------------- lookup ----------------
   logic             look_hit;
   logic [IDX_W-1:0] look_idx;
   logic             look_fault;
   logic             look_ok;

   tlb_match #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .CTX_W   (CTX_W)
   ) u_match (
      .valid_vec (ent_v),
      .vpn_arr   (ent_vpn),
      .ctx_arr   (ent_ctx),
      .look_vpn  (lk_vaddr[VA_W-1:PAGE_W]),
      .look_ctx  (lk_ctx),
      .hit       (look_hit),
      .hit_idx   (look_idx)
   );

   tlb_perm u_perm (
      .hit      (look_hit),
      .perm     (ent_perm[look_idx]),
      .is_write (lk_write),
      .is_user  (lk_user),
      .fault    (look_fault)
   );

   assign look_ok = lk_valid && look_hit && !look_fault;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_hit      <= 1'b0;
         o_pa_valid <= 1'b0;
         o_paddr    <= '0;
         o_fault    <= 1'b0;
         o_walk     <= 1'b0;
      end else begin
         o_hit      <= lk_valid && look_hit;
         o_pa_valid <= look_ok;
         o_fault    <= lk_valid && look_fault;
         o_walk     <= lk_valid && !look_hit;
         o_paddr    <= look_ok ? {ent_ppn[look_idx], lk_vaddr[PAGE_W-1:0]} : '0;
      end
   end

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
   parameter int PAGE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [PAGE_W-1:0] lk_off,
   input logic              fl_all,
   input logic              o_hit,
   input logic              o_pa_valid,
   input logic [PAGE_W-1:0] o_off,
   input logic              o_fault,
   input logic              o_walk
);

   // R2
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!o_pa_valid || o_off == $past(lk_off)));

   // R4
   hit_or_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (o_hit != o_walk));

   // R5
   fault_blocks_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_fault |-> (o_hit && !o_pa_valid));

   // R9
   flush_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_all ##1 lk_valid) |=> !o_hit);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !(o_hit || o_walk || o_fault || o_pa_valid));

endmodule

bind ctx_tlb ctx_tlb_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_off     (lk_vaddr[PAGE_W-1:0]),
   .fl_all     (fl_all),
   .o_hit      (o_hit),
   .o_pa_valid (o_pa_valid),
   .o_off      (o_paddr[PAGE_W-1:0]),
   .o_fault    (o_fault),
   .o_walk     (o_walk)
);

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic [7:0]  lk_ctx = '0;
   logic        lk_write = 1'b0;
   logic        lk_user = 1'b0;
   logic        rf_valid = 1'b0;
   logic [19:0] rf_vpn = '0;
   logic [7:0]  rf_ctx = '0;
   logic [18:0] rf_ppn = '0;
   logic        rf_wr_ok = 1'b0;
   logic        rf_sup_only = 1'b0;
   logic        fl_all = 1'b0;
   logic        fl_ctx_en = 1'b0;
   logic [7:0]  fl_ctx = '0;
   logic        o_hit, o_pa_valid, o_fault, o_walk;
   logic [30:0] o_paddr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ctx_tlb u_ctx_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ctx(lk_ctx),
      .lk_write(lk_write), .lk_user(lk_user),
      .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ctx(rf_ctx), .rf_ppn(rf_ppn),
      .rf_wr_ok(rf_wr_ok), .rf_sup_only(rf_sup_only),
      .fl_all(fl_all), .fl_ctx_en(fl_ctx_en), .fl_ctx(fl_ctx),
      .o_hit(o_hit), .o_pa_valid(o_pa_valid), .o_paddr(o_paddr),
      .o_fault(o_fault), .o_walk(o_walk)
   );

   // {hit, pa_valid, fault, walk, paddr}
   task automatic check(input string tag, input logic [34:0] got, input logic [34:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got hit=%b pav=%b flt=%b walk=%b pa=%h, expected hit=%b pav=%b flt=%b walk=%b pa=%h",
                  tag, got[34], got[33], got[32], got[31], got[30:0],
                  exp[34], exp[33], exp[32], exp[31], exp[30:0]);
      end
   endtask

   task automatic refill(input logic [19:0] vpn, input logic [7:0] ctx,
                         input logic [18:0] ppn, input logic wr_ok, input logic sup);
      rf_valid = 1'b1; rf_vpn = vpn; rf_ctx = ctx; rf_ppn = ppn;
      rf_wr_ok = wr_ok; rf_sup_only = sup;
      @(negedge clk);
      rf_valid = 1'b0;
   endtask

   task automatic flush_ctx(input logic [7:0] ctx);
      fl_ctx_en = 1'b1; fl_ctx = ctx;
      @(negedge clk);
      fl_ctx_en = 1'b0;
   endtask

   // Issue one lookup and compare the registered result one cycle later.
   task automatic lookup(input string tag, input logic [19:0] vpn, input logic [11:0] off,
                         input logic [7:0] ctx, input logic wr, input logic usr,
                         input logic exp_hit, input logic exp_flt, input logic [18:0] exp_ppn);
      logic pav;
      logic [34:0] exp;
      lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_ctx = ctx;
      lk_write = wr; lk_user = usr;
      @(negedge clk);
      pav = exp_hit && !exp_flt;
      exp = {exp_hit, pav, exp_hit && exp_flt, !exp_hit, pav ? {exp_ppn, off} : 31'd0};
      check(tag, {o_hit, o_pa_valid, o_fault, o_walk, o_paddr}, exp);
      lk_valid = 1'b0;
   endtask

   function automatic logic [18:0] base_ppn(input int i);
      return 19'h40000 + 19'(i * 19'h111);
   endfunction

   function automatic logic [7:0] base_ctx(input int i);
      return i[0] ? 8'h22 : 8'h11;
   endfunction

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state at the ports, then a lookup into the empty table
      check("R1 reset outputs", {o_hit, o_pa_valid, o_fault, o_walk, o_paddr}, 35'd0);
      lookup("R1 empty table misses", 20'h00100, 12'h000, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, '0);

      // R7: fill sixteen empty slots; perms wr_ok = i bit0, sup_only = i bit1
      for (int i = 0; i < 16; i++) begin
         refill(20'h00100 + 20'(i), base_ctx(i), base_ppn(i), i[0], i[1]);
      end

      // R2 and R5: every entry against every access kind
      for (int i = 0; i < 16; i++) begin
         for (int a = 0; a < 4; a++) begin
            logic flt;
            flt = (a[0] && !i[0]) || (a[1] && i[1]);
            lookup(flt ? "R5 permission sweep" : "R2 translation sweep",
                   20'h00100 + 20'(i), 12'(i * 12'h101) ^ 12'(a), base_ctx(i),
                   a[0], a[1], 1'b1, flt, base_ppn(i));
         end
      end

      // R12: idle cycle after a hit clears all flags
      lookup("R2 hit before idle", 20'h00103, 12'h7FF, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, base_ppn(3));
      @(negedge clk);
      check("R12 idle cycle", {o_hit, o_pa_valid, o_fault, o_walk, o_paddr}, 35'd0);

      // R3 and R4
      lookup("R3 context mismatch", 20'h00100, 12'h123, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      lookup("R4 unknown page walks", 20'hABCDE, 12'h456, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, '0);

      // R8: table full, pointer at slot 0 after sixteen refills
      refill(20'h00200, 8'h11, 19'h12345, 1'b1, 1'b0);
      lookup("R8 slot0 evicted", 20'h00100, 12'h000, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      lookup("R8 slot1 kept", 20'h00101, 12'h010, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, base_ppn(1));
      lookup("R8 new entry hits", 20'h00200, 12'hABC, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 19'h12345);
      refill(20'h00201, 8'h22, 19'h23456, 1'b1, 1'b0);
      lookup("R8 slot1 evicted", 20'h00101, 12'h000, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      lookup("R8 slot2 kept", 20'h00102, 12'h000, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, base_ppn(2));
      refill(20'h00202, 8'h22, 19'h34567, 1'b1, 1'b0);
      lookup("R8 slot2 evicted", 20'h00102, 12'h000, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, '0);

      // R10: flush context 0x11 (slots 0,4,6,...,14)
      flush_ctx(8'h11);
      lookup("R10 ctx11 entry gone", 20'h00104, 12'h000, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      lookup("R10 ctx11 refill gone", 20'h00200, 12'h000, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      lookup("R10 ctx22 kept", 20'h00202, 12'h321, 8'h22, 1'b1, 1'b0, 1'b1, 1'b0, 19'h34567);
      lookup("R10 ctx22 base kept", 20'h0010F, 12'hFFF, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, base_ppn(15));

      // R7: pointer now names valid slot 3; a free slot must be used instead
      refill(20'h00300, 8'h33, 19'h0AAAA, 1'b1, 1'b0);
      lookup("R7 pointer slot not evicted", 20'h00103, 12'h000, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, base_ppn(3));
      lookup("R7 refill into free slot", 20'h00300, 12'h055, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 19'h0AAAA);

      // R6: duplicate page lands in a higher slot; lower slot wins
      refill(20'h00300, 8'h33, 19'h05555, 1'b1, 1'b0);
      lookup("R6 lowest index wins", 20'h00300, 12'h0AA, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 19'h0AAAA);

      // R11 and R9: refill in the same cycle as a full flush is dropped
      fl_all = 1'b1;
      rf_valid = 1'b1; rf_vpn = 20'h00400; rf_ctx = 8'h44; rf_ppn = 19'h11111;
      rf_wr_ok = 1'b1; rf_sup_only = 1'b0;
      @(negedge clk);
      fl_all = 1'b0; rf_valid = 1'b0;
      lookup("R11 refill dropped", 20'h00400, 12'h000, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      lookup("R9 full flush base", 20'h00103, 12'h000, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      lookup("R9 full flush new", 20'h00300, 12'h000, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, '0);

      // R2 boundary: largest page number and offset
      refill(20'hFFFFF, 8'hFF, 19'h7FFFF, 1'b1, 1'b0);
      lookup("R2 all-ones address", 20'hFFFFF, 12'hFFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 19'h7FFFF);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule